// File: doc/BRIEF.md
# Debug Mailbox with TAP Handshake

This block lets on-chip debug firmware and an external JTAG host swap bytes. The CPU sees two byte-wide registers. One is a holding buffer that the TAP debug data register loads from and unloads into. The other is a flag register that carries a transfer-complete flag, a program-enable bit and a two-bit programming-source field. The TAP controller, instruction decoding and the debug engine sit outside the block. They reach it as one-cycle strobes that are synchronous to the single block clock.

A host transfer runs in four steps. A capture strobe copies the holding buffer into the internal shift register. Each shift strobe moves one bit: TDI enters at the MSB and TDO leaves from the LSB. An update strobe writes the shifted byte back into the holding buffer and raises the transfer-complete flag in the same cycle. The debug engine acknowledges the flag to clear it, and firmware may also set it to ask for a transfer. Any CPU write to the flag register has a side effect: it wipes the host-loaded programming-source bits. The TAP test-logic-reset state empties the holding buffer, in addition to the power-on reset.

Top module: `dbg_mailbox`

## Requirements
- R1: After `rst_n` low, a flag read returns 00h and a buffer read returns 00h. A flag read always returns 0 in bits 7:4, the source field in bits 3:2, program-enable in bit 1 and transfer-complete in bit 0.
- R2: A CPU flag write loads program-enable from write-data bit 1 and transfer-complete from write-data bit 0. Write-data bits 7:2 have no visible effect.
- R3: Any CPU flag write clears both source bits, whatever data is written. This clear wins over a host source load in the same cycle.
- R4: When no CPU flag write occurs, `host_src_ld` copies `host_src` into the source field on the next clock.
- R5: An update strobe sets transfer-complete and copies the shift register into the holding buffer on the next clock. The set wins over a CPU flag write in the same cycle.
- R6: `eng_ack` clears transfer-complete, unless an update or a CPU flag write occurs in the same cycle.
- R7: A CPU buffer write (buffer select with the flag select low) stores all 8 bits. An update in the same cycle takes priority over it.
- R8: `tap_tlr` clears the holding buffer and the shift register on the next clock, and takes priority over update, capture and CPU writes. The flag register is unaffected.
- R9: Capture loads the shift register from the holding buffer. Shift moves the register one bit toward the LSB, with `tap_tdi` entering the MSB. `tap_tdo` always equals the shift-register LSB.
- R10: `cpu_rdata` returns the flag register when `cpu_flag_sel` is high, the buffer when only `cpu_buf_sel` is high, and 00h otherwise. With both selects high, a write goes to the flag register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (also the TAP event clock) |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cpu_flag_sel | input | 1 | Selects the flag register |
| cpu_buf_sel | input | 1 | Selects the holding buffer |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from the selects |
| tap_tlr | input | 1 | TAP in test-logic-reset |
| tap_capture | input | 1 | Capture strobe for the debug data register |
| tap_shift | input | 1 | Shift strobe, one bit per pulse |
| tap_update | input | 1 | Update strobe for the debug data register |
| tap_tdi | input | 1 | Serial data in |
| tap_tdo | output | 1 | Serial data out (shift-register LSB) |
| host_src_ld | input | 1 | Host load strobe for the source field |
| host_src | input | 2 | Host value for the source field |
| eng_ack | input | 1 | Debug engine services and clears transfer-complete |

## Verification
Every stored result appears one clock after its strobe. This covers flag bits, buffer contents, shift-register contents and therefore `tap_tdo`. `cpu_rdata` follows the selects combinationally, with no further register. The bench changes inputs just after a falling edge, lets one rising edge apply them, and compares `cpu_rdata` and `tap_tdo` with a behavioural model at the next falling edge. Each result is therefore checked in exactly the cycle it becomes due. Directed checks, such as the 8-bit serial round trip and same-cycle priority collisions, sample at that same point.

// File: rtl/dbg_mbx_pkg.sv
// Package: shared widths and the flag-register bit layout for the debug mailbox.
// Assumes the flag layout fits inside one data word (checked in the top).
package dbg_mbx_pkg;
    parameter int MBX_DATA_W   = 8;   // CPU word and shift-register width
    parameter int MBX_SRC_W    = 2;   // programming-source field width
    localparam int FLG_DONE_BIT = 0;  // transfer-complete position
    localparam int FLG_PEN_BIT  = 1;  // program-enable position
    localparam int FLG_SRC_LSB  = 2;  // source field low bit
endpackage

// File: rtl/dbg_shift_reg.sv
// Module: serial debug shift register.
// Loads in parallel on capture and shifts toward the LSB on shift, with the
// serial input entering at the MSB. Assumes one strobe per event; clear wins.
module dbg_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              shf,
    input  logic [DATA_W-1:0] par_in,
    input  logic              sin,
    output logic [DATA_W-1:0] sr_q,
    output logic              sout
);
    logic [DATA_W-1:0] shift_nx;

    // Build the shifted value bit by bit; the top bit takes the serial input.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == DATA_W - 1) begin : g_top
            assign shift_nx[i] = sin;
        end else begin : g_mid
            assign shift_nx[i] = sr_q[i+1];
        end
    end

    // Register update: reset/clear, then capture, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q <= '0;
        end else if (cap) begin
            sr_q <= par_in;
        end else if (shf) begin
            sr_q <= shift_nx;
        end
    end

    // Serial output is the current LSB.
    assign sout = sr_q[0];
endmodule

// File: rtl/dbg_hold_buf.sv
// Module: parallel holding buffer between the CPU and the shift register.
// Clear (test-logic-reset) beats update, and update beats a CPU write.
module dbg_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] buf_q
);
    // Holding register with fixed source priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            buf_q <= '0;
        end else if (upd) begin
            buf_q <= upd_data;
        end else if (cpu_we) begin
            buf_q <= cpu_wdata;
        end
    end
endmodule

// File: rtl/dbg_flag_reg.sv
// Module: handshake flag register (transfer-complete, program-enable, source).
// A CPU write touches only the enable and complete bits and wipes the source
// field. A hardware update set outranks the CPU write; the engine ack is lowest.
module dbg_flag_reg #(
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic             wr_pen,
    input  logic             wr_done,
    input  logic             upd,
    input  logic             eng_ack,
    input  logic             host_ld,
    input  logic [SRC_W-1:0] host_src,
    output logic [SRC_W-1:0] src_q,
    output logic             pen_q,
    output logic             done_q
);
    // Transfer-complete: update set > CPU write > engine clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (upd) begin
            done_q <= 1'b1;
        end else if (cpu_we) begin
            done_q <= wr_done;
        end else if (eng_ack) begin
            done_q <= 1'b0;
        end
    end

    // Program-enable: written only by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q <= 1'b0;
        end else if (cpu_we) begin
            pen_q <= wr_pen;
        end
    end

    // Source field: any CPU flag write clears it, else the host may load it.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_we) begin
            src_q <= '0;
        end else if (host_ld) begin
            src_q <= host_src;
        end
    end
endmodule

// File: rtl/dbg_mailbox.sv
// Module: debug mailbox top. Joins the CPU register port, the TAP event strobes
// and the host source load. Assumes every TAP event is a one-clock strobe that
// is synchronous to clk. Read data is a combinational mux of register state.
module dbg_mailbox #(
    parameter int DATA_W = dbg_mbx_pkg::MBX_DATA_W,
    parameter int SRC_W  = dbg_mbx_pkg::MBX_SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_flag_sel,
    input  logic              cpu_buf_sel,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tap_tlr,
    input  logic              tap_capture,
    input  logic              tap_shift,
    input  logic              tap_update,
    input  logic              tap_tdi,
    output logic              tap_tdo,
    input  logic              host_src_ld,
    input  logic [SRC_W-1:0]  host_src,
    input  logic              eng_ack
);
    import dbg_mbx_pkg::*;

    localparam int FLAG_W = FLG_SRC_LSB + SRC_W;
    localparam int PAD_W  = DATA_W - FLAG_W;

    logic              flag_we;
    logic              buf_we;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg_q;
    logic [SRC_W-1:0]  flag_src;
    logic              flag_pen;
    logic              flag_done;
    logic [DATA_W-1:0] flag_word;

    // Elaboration guard: the flag layout must fit in one word.
    if (PAD_W < 1) begin : g_bad_width
        initial $error("dbg_mailbox: DATA_W too small for flag layout");
    end

    // Write decode: the flag select takes the write when both selects are high.
    assign flag_we = cpu_wr && cpu_flag_sel;
    assign buf_we  = cpu_wr && cpu_buf_sel && !cpu_flag_sel;

    dbg_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tap_tlr),
        .cap    (tap_capture),
        .shf    (tap_shift),
        .par_in (hold_q),
        .sin    (tap_tdi),
        .sr_q   (shreg_q),
        .sout   (tap_tdo)
    );

    dbg_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tap_tlr),
        .upd       (tap_update),
        .upd_data  (shreg_q),
        .cpu_we    (buf_we),
        .cpu_wdata (cpu_wdata),
        .buf_q     (hold_q)
    );

    dbg_flag_reg #(.SRC_W(SRC_W)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (flag_we),
        .wr_pen   (cpu_wdata[FLG_PEN_BIT]),
        .wr_done  (cpu_wdata[FLG_DONE_BIT]),
        .upd      (tap_update),
        .eng_ack  (eng_ack),
        .host_ld  (host_src_ld),
        .host_src (host_src),
        .src_q    (flag_src),
        .pen_q    (flag_pen),
        .done_q   (flag_done)
    );

    // Assemble the flag word with the unused upper bits tied to zero.
    assign flag_word = {{PAD_W{1'b0}}, flag_src, flag_pen, flag_done};

    // Read mux: flag first, then buffer, else zero.
    always_comb begin
        if (cpu_flag_sel) begin
            cpu_rdata = flag_word;
        end else if (cpu_buf_sel) begin
            cpu_rdata = hold_q;
        end else begin
            cpu_rdata = '0;
        end
    end
endmodule

// File: rtl/dbg_mailbox_chk.sv
// Checker: temporal properties of the debug mailbox, bound to the top.
module dbg_mailbox_chk #(
    parameter int DATA_W = 8,
    parameter int SRC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_flag_sel,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              tap_tlr,
    input logic              tap_capture,
    input logic              tap_shift,
    input logic              tap_update,
    input logic              tap_tdi,
    input logic              eng_ack,
    input logic [SRC_W-1:0]  src_q,
    input logic              pen_q,
    input logic              done_q,
    input logic [DATA_W-1:0] buf_q,
    input logic [DATA_W-1:0] sr_q
);
    localparam int FLAG_W = SRC_W + 2;

    // R1: upper flag bits always read zero.
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_flag_sel |-> (cpu_rdata[DATA_W-1:FLAG_W] == '0));

    // R2: program-enable changes only through a CPU flag write.
    p_pen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_flag_sel) |=> $stable(pen_q));

    // R3: a CPU flag write leaves the source field empty.
    p_src_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_flag_sel) |=> (src_q == '0));

    // R5: update raises transfer-complete.
    p_update_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tap_update |=> done_q);

    // R5: update copies the shift register into the buffer.
    p_update_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_update && !tap_tlr) |=> (buf_q == $past(sr_q)));

    // R6: an unopposed engine ack clears transfer-complete.
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ack && !tap_update && !(cpu_wr && cpu_flag_sel)) |=> !done_q);

    // R8: test-logic-reset empties buffer and shift register.
    p_tlr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tlr |=> (buf_q == '0 && sr_q == '0));

    // R9: a shift moves data toward the LSB with TDI at the MSB.
    p_shift_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_shift && !tap_capture && !tap_tlr) |=>
            (sr_q == {$past(tap_tdi), $past(sr_q[DATA_W-1:1])}));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr       (cpu_wr),
    .cpu_flag_sel (cpu_flag_sel),
    .cpu_rdata    (cpu_rdata),
    .tap_tlr      (tap_tlr),
    .tap_capture  (tap_capture),
    .tap_shift    (tap_shift),
    .tap_update   (tap_update),
    .tap_tdi      (tap_tdi),
    .eng_ack      (eng_ack),
    .src_q        (flag_src),
    .pen_q        (flag_pen),
    .done_q       (flag_done),
    .buf_q        (hold_q),
    .sr_q         (shreg_q)
);

// File: tb/tb_dbg_mailbox.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks of the corner cases.
module tb_dbg_mailbox;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_flag_sel, cpu_buf_sel, cpu_wr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       tap_tlr, tap_capture, tap_shift, tap_update, tap_tdi, tap_tdo;
    logic       host_src_ld;
    logic [1:0] host_src;
    logic       eng_ack;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    int m_src, m_pen, m_done, m_buf, m_sr;

    always #2.5 clk = ~clk;

    dbg_mailbox dut (
        .clk(clk), .rst_n(rst_n), .cpu_flag_sel(cpu_flag_sel),
        .cpu_buf_sel(cpu_buf_sel), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .tap_tlr(tap_tlr), .tap_capture(tap_capture),
        .tap_shift(tap_shift), .tap_update(tap_update), .tap_tdi(tap_tdi),
        .tap_tdo(tap_tdo), .host_src_ld(host_src_ld), .host_src(host_src),
        .eng_ack(eng_ack)
    );

    // Reference model: advances on each rising edge from the stable inputs.
    always @(posedge clk) begin
        int n_src, n_pen, n_done, n_buf, n_sr;
        bit fw;
        if (!rst_n) begin
            m_src = 0; m_pen = 0; m_done = 0; m_buf = 0; m_sr = 0;
        end else begin
            fw = cpu_wr && cpu_flag_sel;
            n_buf = m_buf;
            if (tap_tlr) n_buf = 0;
            else if (tap_update) n_buf = m_sr;
            else if (cpu_wr && cpu_buf_sel && !cpu_flag_sel) n_buf = cpu_wdata;
            n_sr = m_sr;
            if (tap_tlr) n_sr = 0;
            else if (tap_capture) n_sr = m_buf;
            else if (tap_shift) n_sr = (m_sr >> 1) | (int'(tap_tdi) << 7);
            n_done = m_done;
            if (tap_update) n_done = 1;
            else if (fw) n_done = cpu_wdata[0];
            else if (eng_ack) n_done = 0;
            n_pen = fw ? int'(cpu_wdata[1]) : m_pen;
            n_src = m_src;
            if (fw) n_src = 0;
            else if (host_src_ld) n_src = host_src;
            m_src = n_src; m_pen = n_pen; m_done = n_done; m_buf = n_buf; m_sr = n_sr;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_read();
        if (cpu_flag_sel) return (m_src << 2) | (m_pen << 1) | m_done;
        if (cpu_buf_sel) return m_buf;
        return 0;
    endfunction

    // Advance one clock and compare the outputs at the falling edge.
    task automatic tick();
        @(negedge clk);
        chk(cur_req, "rdata", int'(cpu_rdata), model_read());
        chk(cur_req, "tdo", int'(tap_tdo), m_sr & 1);
    endtask

    task automatic idle();
        cpu_wr = 0; tap_tlr = 0; tap_capture = 0; tap_shift = 0;
        tap_update = 0; tap_tdi = 0; host_src_ld = 0; eng_ack = 0;
    endtask

    task automatic rd_flag(); cpu_flag_sel = 1; cpu_buf_sel = 0; endtask
    task automatic rd_buf();  cpu_flag_sel = 0; cpu_buf_sel = 1; endtask

    task automatic wr_flag(input logic [7:0] d);
        idle(); rd_flag(); cpu_wr = 1; cpu_wdata = d; tick(); idle();
    endtask

    task automatic wr_buf(input logic [7:0] d);
        idle(); rd_buf(); cpu_wr = 1; cpu_wdata = d; tick(); idle();
    endtask

    task automatic host_load(input logic [1:0] s);
        idle(); host_src_ld = 1; host_src = s; tick(); idle();
    endtask

    initial begin
        logic [7:0] rx;
        logic [7:0] tx;
        rst_n = 0; cpu_flag_sel = 0; cpu_buf_sel = 0; cpu_wdata = 0; host_src = 0;
        idle();
        repeat (3) tick();
        rst_n = 1;

        // R1: reset state and layout
        cur_req = "R1";
        rd_flag(); tick(); chk("R1", "flag after reset", int'(cpu_rdata), 0);
        rd_buf();  tick(); chk("R1", "buf after reset", int'(cpu_rdata), 0);

        // R2: write only touches enable/complete
        cur_req = "R2";
        wr_flag(8'hFF); rd_flag(); tick();
        chk("R2", "flag after FF write", int'(cpu_rdata), 8'h03);

        // R4: host loads source field
        cur_req = "R4";
        host_load(2'b11); rd_flag(); tick();
        chk("R4", "flag after host load", int'(cpu_rdata), 8'h0F);

        // R3: any flag write clears source, even writing ones there
        cur_req = "R3";
        wr_flag(8'h0C); rd_flag(); tick();
        chk("R3", "src cleared by write", int'(cpu_rdata), 8'h00);
        host_load(2'b10);
        idle(); rd_flag(); cpu_wr = 1; cpu_wdata = 8'h02; host_src_ld = 1; host_src = 2'b01;
        tick(); idle(); tick();
        chk("R3", "write beats host load", int'(cpu_rdata), 8'h02);

        // R6: engine ack clears transfer-complete
        cur_req = "R6";
        wr_flag(8'h01); idle(); rd_flag(); eng_ack = 1; tick(); idle(); tick();
        chk("R6", "ack clears done", int'(cpu_rdata), 8'h00);

        // R7: buffer read/write
        cur_req = "R7";
        wr_buf(8'h5A); rd_buf(); tick();
        chk("R7", "buf 5A", int'(cpu_rdata), 8'h5A);
        wr_buf(8'hA5); rd_buf(); tick();
        chk("R7", "buf A5", int'(cpu_rdata), 8'hA5);

        // R9: capture and shift round trip, R5: update
        cur_req = "R9";
        idle(); tap_capture = 1; tick(); idle();
        tx = 8'h3C;
        for (int i = 0; i < 8; i++) begin
            rx[i] = tap_tdo;
            tap_shift = 1; tap_tdi = tx[i]; tick(); idle();
        end
        chk("R9", "bits out on tdo", int'(rx), 8'hA5);
        cur_req = "R5";
        host_load(2'b11);
        // update collides with a CPU flag write that clears done
        idle(); rd_flag(); tap_update = 1; cpu_wr = 1; cpu_wdata = 8'h00; tick(); idle(); tick();
        chk("R5", "update beats write, src wiped", int'(cpu_rdata), 8'h01);
        rd_buf(); tick();
        chk("R5", "buf after update", int'(cpu_rdata), 8'h3C);

        // R7: update wins over CPU buffer write
        cur_req = "R7";
        idle(); tap_capture = 1; tick(); idle();
        tap_shift = 1; tap_tdi = 1; tick(); idle();
        rd_buf(); tap_update = 1; cpu_wr = 1; cpu_wdata = 8'h11; tick(); idle(); tick();
        chk("R7", "update beats buf write", int'(cpu_rdata), 8'h9E);

        // R8: test-logic-reset clears buffer and shift register, not flags
        cur_req = "R8";
        wr_buf(8'hC3);
        idle(); tap_capture = 1; tick(); idle();
        rd_buf(); tap_tlr = 1; tap_update = 1; cpu_wr = 1; cpu_wdata = 8'h77; tick(); idle(); tick();
        chk("R8", "buf after tlr", int'(cpu_rdata), 0);
        chk("R8", "tdo after tlr", int'(tap_tdo), 0);
        rd_flag(); tick();
        chk("R8", "flags kept through tlr", int'(cpu_rdata), 8'h01);

        // R10: read selection
        cur_req = "R10";
        wr_buf(8'h66);
        cpu_flag_sel = 1; cpu_buf_sel = 1; tick();
        chk("R10", "both selects read flag", int'(cpu_rdata), 8'h01);
        cpu_wr = 1; cpu_wdata = 8'h99; tick(); idle();
        rd_buf(); tick();
        chk("R10", "dual-select write skips buf", int'(cpu_rdata), 8'h66);
        cpu_flag_sel = 0; cpu_buf_sel = 0; tick();
        chk("R10", "no select reads zero", int'(cpu_rdata), 0);

        // R1: power-on reset mid-run clears everything
        cur_req = "R1";
        host_load(2'b01);
        rst_n = 0; tick(); rst_n = 1;
        rd_flag(); tick(); chk("R1", "flag after re-reset", int'(cpu_rdata), 0);
        rd_buf();  tick(); chk("R1", "buf after re-reset", int'(cpu_rdata), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule